// File: doc/BRIEF.md
# Packet Framer with 32-to-128 Width Packing

This block turns a stream of size-prefixed payload records into framed packets. Each record arrives on a 32-bit valid/ready stream. The first word gives the payload length in bytes. The payload words follow, and the last word is flagged with an end marker that carries an error bit. For each record the block emits three kinds of item, in this order: a 128-bit header, the payload packed four words per 128-bit beat, and a 128-bit footer.

Header and footer beats are written to one output FIFO and payload beats to another. Each FIFO has a plain write strobe and reports a full flag. The header combines the record size with software-set configuration: a destination node ID, a destination buffer address that moves forward packet by packet inside a base/limit window, and a running sequence number. Configuration is written through a small address/data/write-enable port. Staged values are adopted only when the next packet starts.

Top module: `pkt_framer`

## Requirements
- R1: After reset, with neither FIFO full, `in_ready` is 1 and no FIFO write strobe is active. The sequence number is 0, the destination address, base and node ID are 0, and the limit is all ones.
- R2: When the size word is accepted, one header beat is written to the header/footer FIFO in that same cycle. Its layout is: [15:0] node ID, [31:16] size word bits 15:0 (payload bytes), [63:32] sequence number, [127:64] destination address.
- R3: Payload words are packed in arrival order. The first word of a beat sits in bits 31:0 and each later word takes the next higher 32-bit lane. A beat is written to the payload FIFO in the cycle its fourth word, or the record's last word, is accepted.
- R4: When a record's word count is not a multiple of four, the unused lanes of its final beat are zero.
- R5: One cycle after the last payload word is accepted, the footer goes to the header/footer FIFO, held back while that FIFO is full, and no input is accepted meanwhile. Its layout is: [15:0] number of payload beats, [16] error bit of the end marker, all other bits zero.
- R6: The sequence number in the header starts at 0 and rises by one for each packet.
- R7: After each footer the destination address moves forward by 16 bytes times the beat count. If the result exceeds the limit register, the address is reloaded from the base register instead.
- R8: `in_ready` is low whenever the FIFO the next input word is headed for is full: the header/footer FIFO for a size word, the payload FIFO for a payload word. No FIFO is written while its full flag is set.
- R9: Configuration writes take effect only at the next packet start. A base, limit or address write made during a packet does not change that packet's header or its end-of-packet address update.
- R10: A size word that carries the end marker is an empty record. It yields a header, no payload beat, and a footer with a beat count of 0 and the marker's error bit.
- R11: Configuration address map on `cfg_addr`: 0 node ID (bits 15:0), 1 and 2 destination address low and high words, 3 and 4 base low and high words, 5 and 6 limit low and high words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Size word or payload word |
| in_last | input | 1 | End-of-record marker |
| in_err | input | 1 | Error bit, meaningful with `in_last` |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| hf_wr | output | 1 | Header/footer FIFO write strobe |
| hf_data | output | 128 | Header or footer beat |
| hf_full | input | 1 | Header/footer FIFO full |
| pl_wr | output | 1 | Payload FIFO write strobe |
| pl_data | output | 128 | Payload beat |
| pl_full | input | 1 | Payload FIFO full |

## Verification
The assertions check on every cycle that:
- neither FIFO is written while it is full;
- the two FIFOs never take a write in the same cycle;
- a single-lane final beat carries zeros above lane 0;
- the sequence counter moves by one for each header;
- the cycle after the last payload word either writes the footer or stalls on a full FIFO, with input held off.

Only the bench's scenarios can show the rest. That covers the exact header and footer contents, the lane order of packed words, the address moving forward and wrapping inside the base/limit window, and the rule that configuration written mid-packet waits for the next packet start. The bench traces each of these through a model of the configuration and address state.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
  localparam int WORD_W     = 32;
  localparam int LANES      = 4;
  localparam int BEAT_W     = WORD_W * LANES;
  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int CNT_W      = 16;
  localparam int ADDR_W     = 64;
  localparam int CADDR_W    = 3;

  typedef enum logic [1:0] {ST_SIZE, ST_PAY, ST_FOOT} fr_state_e;

  typedef struct packed {
    logic [15:0]       node;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] lim;
  } cfg_t;

  // Header: node | byte length | sequence | destination address (low to high)
  function automatic logic [BEAT_W-1:0] make_header(input logic [15:0] node,
                                                    input logic [15:0] len,
                                                    input logic [31:0] seq,
                                                    input logic [ADDR_W-1:0] addr);
    return {addr, seq, len, node};
  endfunction

  function automatic logic [BEAT_W-1:0] make_footer(input logic [CNT_W-1:0] beats,
                                                    input logic err);
    logic [BEAT_W-1:0] f;
    f = '0;
    f[CNT_W-1:0] = beats;
    f[CNT_W]     = err;
    return f;
  endfunction

  // Next destination address: advance by padded size, fall back to base past limit
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] cur,
                                                  input logic [CNT_W-1:0]  beats,
                                                  input logic [ADDR_W-1:0] base,
                                                  input logic [ADDR_W-1:0] lim);
    logic [ADDR_W-1:0] nxt;
    nxt = cur + (ADDR_W'(beats) << $clog2(BEAT_BYTES));
    return (nxt > lim) ? base : nxt;
  endfunction
endpackage

// File: rtl/pkt_framer_cfg.sv
module pkt_framer_cfg
  import pkt_framer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CADDR_W-1:0] addr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               apply,
  output cfg_t               stg,
  output cfg_t               act,
  output logic               addr_pend,
  output logic [ADDR_W-1:0]  addr_val
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg       <= '{node: '0, base: '0, lim: '1};
      act       <= '{node: '0, base: '0, lim: '1};
      addr_pend <= 1'b0;
      addr_val  <= '0;
    end else begin
      if (apply) begin
        act       <= stg;
        addr_pend <= 1'b0;
      end
      if (we) begin
        case (addr)
          3'd0: stg.node <= wdata[15:0];
          3'd1: begin addr_val[31:0]  <= wdata; addr_pend <= 1'b1; end
          3'd2: begin addr_val[63:32] <= wdata; addr_pend <= 1'b1; end
          3'd3: stg.base[31:0]  <= wdata;
          3'd4: stg.base[63:32] <= wdata;
          3'd5: stg.lim[31:0]   <= wdata;
          3'd6: stg.lim[63:32]  <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pkt_framer_pack.sv
module pkt_framer_pack
  import pkt_framer_pkg::*;
#(
  parameter int N_LANES = LANES,
  parameter int W       = WORD_W,
  localparam int LIDX_W = $clog2(N_LANES)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [W-1:0]        word,
  input  logic                last,
  output logic                beat_v,
  output logic [W*N_LANES-1:0] beat_data,
  output logic [LIDX_W:0]     lanes_used
);
  logic [LIDX_W-1:0] lane;
  logic [W-1:0]      held [N_LANES-1];
  logic              lane_top;

  assign lane_top   = (lane == LIDX_W'(N_LANES-1));
  assign beat_v     = take && (last || lane_top);
  assign lanes_used = {1'b0, lane} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) lane <= '0;
    else if (take) lane <= beat_v ? '0 : lane + 1'b1;
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    if (g < N_LANES - 1) begin : g_held
      always_ff @(posedge clk) begin
        if (!rst_n) held[g] <= '0;
        else if (take && !beat_v && lane == LIDX_W'(g)) held[g] <= word;
      end
      assign beat_data[g*W +: W] = (lane == LIDX_W'(g)) ? word :
                                   (lane >  LIDX_W'(g)) ? held[g] : '0;
    end else begin : g_top
      assign beat_data[g*W +: W] = (lane == LIDX_W'(g)) ? word : '0;
    end
  end
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import pkt_framer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0]  cfg_wdata,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_data,
  input  logic               in_last,
  input  logic               in_err,
  output logic               in_ready,
  output logic               hf_wr,
  output logic [BEAT_W-1:0]  hf_data,
  input  logic               hf_full,
  output logic               pl_wr,
  output logic [BEAT_W-1:0]  pl_data,
  input  logic               pl_full
);
  localparam int LIDX_W = $clog2(LANES);

  fr_state_e         state;
  logic [31:0]       seq;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  beat_cnt;
  logic              err_q;

  cfg_t              stg, act;
  logic              addr_pend;
  logic [ADDR_W-1:0] addr_val;

  // named internal events
  logic take, hdr_fire, pay_take, foot_fire, beat_v;
  logic [LIDX_W:0]   lanes_used;
  logic [ADDR_W-1:0] addr_use;

  assign in_ready  = (state == ST_SIZE) ? !hf_full :
                     (state == ST_PAY)  ? !pl_full : 1'b0;
  assign take      = in_valid && in_ready;
  assign hdr_fire  = take && (state == ST_SIZE);
  assign pay_take  = take && (state == ST_PAY);
  assign foot_fire = (state == ST_FOOT) && !hf_full;
  assign addr_use  = addr_pend ? addr_val : cur_addr;

  pkt_framer_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .apply(hdr_fire), .stg(stg), .act(act), .addr_pend(addr_pend), .addr_val(addr_val)
  );

  pkt_framer_pack u_pack (
    .clk(clk), .rst_n(rst_n), .take(pay_take), .word(in_data), .last(in_last),
    .beat_v(beat_v), .beat_data(pl_data), .lanes_used(lanes_used)
  );

  assign pl_wr   = beat_v;
  assign hf_wr   = hdr_fire || foot_fire;
  assign hf_data = foot_fire ? make_footer(beat_cnt, err_q)
                             : make_header(stg.node, in_data[15:0], seq, addr_use);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_SIZE;
      seq      <= '0;
      cur_addr <= '0;
      beat_cnt <= '0;
      err_q    <= 1'b0;
    end else begin
      case (state)
        ST_SIZE: if (hdr_fire) begin
          cur_addr <= addr_use;
          seq      <= seq + 1'b1;
          beat_cnt <= '0;
          err_q    <= in_last && in_err;
          state    <= in_last ? ST_FOOT : ST_PAY;
        end
        ST_PAY: if (pay_take) begin
          if (beat_v) beat_cnt <= beat_cnt + 1'b1;
          if (in_last) begin
            err_q <= in_err;
            state <= ST_FOOT;
          end
        end
        ST_FOOT: if (foot_fire) begin
          cur_addr <= addr_step(cur_addr, beat_cnt, act.base, act.lim);
          state    <= ST_SIZE;
        end
        default: state <= ST_SIZE;
      endcase
    end
  end

  a_r8_hf_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    hf_wr |-> !hf_full);
  a_r8_pl_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    pl_wr |-> !pl_full);
  a_r2_one_fifo_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !(hf_wr && pl_wr));
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_wr && lanes_used == 1) |-> (pl_data[BEAT_W-1:WORD_W] == '0));
  a_r6_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire |=> (seq == $past(seq) + 32'd1));
  a_r5_footer_next: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_take && in_last) |=> (!in_ready && (hf_wr == !hf_full)));
endmodule

// File: tb/pkt_framer_test.sv
`timescale 1ns/1ps
module pkt_framer_test;
  logic         clk = 0, rst_n = 0;
  logic         cfg_we = 0;
  logic [2:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic         in_valid = 0, in_last = 0, in_err = 0;
  logic [31:0]  in_data = '0;
  logic         in_ready, hf_wr, pl_wr;
  logic [127:0] hf_data, pl_data;
  logic         hf_full = 0, pl_full = 0;

  int n_tests = 0, n_fail = 0;

  pkt_framer uut (.*);

  always #4 clk = ~clk;

  // scoreboard queues
  logic [127:0] hq[$], pq[$];
  string        htag[$], ptag[$];

  // bench model of configuration and pointer state
  logic [15:0] node_s;
  logic [63:0] base_s, lim_s, addr_s, base_a, lim_a, cur;
  bit          pend;
  logic [31:0] seq;

  task automatic chk(string tag, logic [127:0] act_v, logic [127:0] exp_v);
    n_tests++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (hf_wr) begin
        if (hq.size() == 0) chk("R2 unexpected header/footer write", hf_data, 'x);
        else chk(htag.pop_front(), hf_data, hq.pop_front());
        if (hf_full) chk("R8 write to full hf fifo", 1, 0);
      end
      if (pl_wr) begin
        if (pq.size() == 0) chk("R3 unexpected payload write", pl_data, 'x);
        else chk(ptag.pop_front(), pl_data, pq.pop_front());
        if (pl_full) chk("R8 write to full pl fifo", 1, 0);
      end
    end
  end

  task automatic cfg_write(logic [2:0] a, logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
    case (a)
      3'd0: node_s = d[15:0];
      3'd1: begin addr_s[31:0] = d; pend = 1; end
      3'd2: begin addr_s[63:32] = d; pend = 1; end
      3'd3: base_s[31:0] = d;
      3'd4: base_s[63:32] = d;
      3'd5: lim_s[31:0] = d;
      3'd6: lim_s[63:32] = d;
      default: ;
    endcase
  endtask

  task automatic put_word(logic [31:0] d, bit last, bit err);
    in_valid = 1; in_data = d; in_last = last; in_err = err;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  function automatic logic [31:0] wv(logic [31:0] s, int i);
    return 32'hC000_0000 | (s << 12) | 32'(i);
  endfunction

  task automatic send_record(int bytes, int nwords, bit err, string tag,
                             bit midw = 0, logic [2:0] ma = 0, logic [31:0] md = 0);
    logic [127:0] acc;
    logic [127:0] ft;
    logic [63:0]  nxt;
    logic [31:0]  s;
    int           lane, beats;
    // header: staged config adopted at packet start
    base_a = base_s; lim_a = lim_s;
    if (pend) begin cur = addr_s; pend = 0; end
    s = seq;
    hq.push_back({cur, s, 16'(bytes), node_s}); htag.push_back({"R2/R6 header ", tag});
    seq++;
    acc = '0; lane = 0; beats = 0;
    for (int i = 0; i < nwords; i++) begin
      acc[lane*32 +: 32] = wv(s, i);
      lane++;
      if (lane == 4 || i == nwords - 1) begin
        pq.push_back(acc); ptag.push_back({"R3/R4 payload ", tag});
        acc = '0; lane = 0; beats++;
      end
    end
    ft = '0; ft[15:0] = 16'(beats); ft[16] = err;
    hq.push_back(ft); htag.push_back({"R5/R10 footer ", tag});
    put_word(32'(bytes), nwords == 0, (nwords == 0) ? err : 1'b0);
    for (int i = 0; i < nwords; i++) begin
      put_word(wv(s, i), i == nwords - 1, (i == nwords - 1) ? err : 1'b0);
      if (i == 0 && midw) cfg_write(ma, md);
    end
    nxt = cur + 64'(beats) * 64'd16;
    cur = (nxt > lim_a) ? base_a : nxt;
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 100000);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    node_s = 0; base_s = 0; lim_s = '1; addr_s = 0; pend = 0; cur = 0; seq = 0;
    base_a = 0; lim_a = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 in_ready after reset", in_ready, 1);
    chk("R1 no hf write after reset", hf_wr, 0);
    chk("R1 no pl write after reset", pl_wr, 0);
    @(posedge clk); #1;

    send_record(16, 4, 0, "full beat");           // R3 exact fit
    send_record(20, 5, 1, "padded err");          // R4 one-lane tail, R5 error bit
    send_record(0, 0, 1, "empty");                // R10
    send_record(12, 3, 0, "three lanes");         // R4

    // R11 register map: node, address, base, limit
    cfg_write(3'd0, 32'h0000_0055);
    cfg_write(3'd1, 32'h0000_1000);
    cfg_write(3'd2, 32'h0000_0000);
    cfg_write(3'd3, 32'h0000_0100);
    cfg_write(3'd4, 32'h0000_0000);
    cfg_write(3'd5, 32'h0000_1030);
    cfg_write(3'd6, 32'h0000_0000);
    send_record(32, 8, 0, "R11 cfg map");         // 0x1000 -> 0x1020
    send_record(32, 8, 0, "R7 advance");          // 0x1020 -> 0x1040 > limit -> base
    send_record(16, 4, 0, "R7 wrapped");          // header shows 0x100

    // R9: limit lowered mid-packet must not affect this packet's update
    send_record(16, 4, 0, "R9 mid write", 1, 3'd5, 32'h0000_0000);
    send_record(16, 4, 0, "R9 after");            // header uses un-wrapped address
    send_record(4, 1, 0, "R9 applied");           // header shows base: new limit now active

    // R9: address written mid-packet used by the next header, not this packet's end
    send_record(8, 2, 0, "R9 addr mid", 1, 3'd1, 32'h0000_5000);
    send_record(4, 1, 0, "R9 addr next");

    // R8: payload FIFO full blocks payload words
    pl_full = 1;
    fork
      send_record(24, 6, 0, "R8 pl stall");
      begin
        repeat (6) @(negedge clk);
        chk("R8 in_ready low with pl_full", in_ready, 0);
        chk("R8 no pl write with pl_full", pl_wr, 0);
        @(posedge clk); #1;
        pl_full = 0;
      end
    join

    // R8: header/footer FIFO full blocks the size word
    hf_full = 1;
    fork
      send_record(4, 1, 1, "R8 hf stall");
      begin
        repeat (4) @(negedge clk);
        chk("R8 in_ready low with hf_full", in_ready, 0);
        chk("R8 no hf write with hf_full", hf_wr, 0);
        @(posedge clk); #1;
        hf_full = 0;
      end
    join

    repeat (10) @(posedge clk);
    chk("R5 all expected header/footer beats seen", 128'(hq.size()), 0);
    chk("R3 all expected payload beats seen", 128'(pq.size()), 0);
    finish_run();
  end
endmodule